// File: doc/BRIEF.md
# Over-Temperature Gating and Reset Qualification Controller

This controller holds the global protection and reset logic of an eight-channel low-side driver. It keeps the channel command word that the serial block writes. It forces every driver off while the chip reports over-temperature, and the command word itself is not touched. When the temperature flag drops, the stored command drives the channels again. If a new frame arrives during the hot phase, or a reset occurs, that value is what the channels take up afterwards.

The raw external reset pin is synchronised and passed through a width filter that counts oscillator ticks. The filter gives an internal reset only when the pin has stayed low for a minimum time. That qualified reset is combined with the power-on reset. The reset clears the command word, the status snapshot and the timebase.

A timebase prescaler supplies the slow tick used by the protection timers. A test level input shortens the prescaler by a fixed power of two. The same input routes the oscillator divided by two to a pin that the serial output can select.

Top module: `prot_reset_ctrl`

## Requirements
- R1: Command bit i at 0 turns channel i on and at 1 turns it off. A word presented with `load_i` appears on `drv_on_o` (1 = driver on) after the next clock edge.
- R2: After `ovt_i` rises, `drv_on_o` is all zero from the second clock edge on and stays zero while the flag is high. The command word is kept.
- R3: After `ovt_i` falls, the held command word drives `drv_on_o` again from the second clock edge on.
- R4: A word loaded while `ovt_i` is high does not turn any driver on during the hot phase. It is the word applied when the flag clears.
- R5: `capture_i` stores the present driver state into `status_o`, bit i = 1 meaning channel i is off. During over-temperature every bit reads 1.
- R6: A low pulse on `ext_rst_ni` shorter than `RST_MIN_TICKS` clock ticks has no effect on `sys_rst_no`, `drv_on_o` or the command word.
- R7: When `ext_rst_ni` stays low, `sys_rst_no` goes low on the edge `RST_MIN_TICKS + 2` after the pin falls (two sync stages plus the count). It stays low until the pin rises. The command word is then cleared, so all channels stay off until a new load.
- R8: While `rst_ni` is low, `sys_rst_no` is low, all drivers are off and `status_o` is all ones.
- R9: In normal mode `tick_o` pulses for one cycle every 2^`PRESCALE_W` cycles.
- R10: With `test_i` high, `tick_o` pulses every 2^(`PRESCALE_W` - `TEST_SHIFT`) cycles and `osc_half_o` toggles on every clock. With `test_i` low, `osc_half_o` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | Raw external reset pin, active low |
| ovt_i | input | 1 | Over-temperature flag, hysteresis applied upstream |
| test_i | input | 1 | Test mode level |
| load_i | input | 1 | One-cycle strobe: serial frame latched |
| load_data_i | input | N_CH | Frame command word, 0 = channel on |
| capture_i | input | 1 | One-cycle strobe: snapshot driver status |
| drv_on_o | output | N_CH | Driver enables, 1 = on |
| status_o | output | N_CH | Status snapshot, 1 = channel off |
| sys_rst_no | output | 1 | Combined internal reset, active low |
| tick_o | output | 1 | Timebase tick, one cycle wide |
| osc_half_o | output | 1 | Oscillator divided by two in test mode, else 0 |

## Verification
Loads change `drv_on_o` one edge later. The over-temperature flag and the test level act two edges later because of their synchronisers. A qualified external reset shows on `sys_rst_no` `RST_MIN_TICKS + 2` edges after the pin falls, and the cleared command word reaches `drv_on_o` one edge after that. Each directed task drives its inputs on the falling clock edge, counts rising edges to the due cycle, and samples on a falling edge. Checks fall both one edge before and at the due cycle where the timing matters. Tick periods are measured edge by edge between consecutive pulses.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  // synchroniser slot assignment
  localparam int unsigned SLOT_PIN  = 0;
  localparam int unsigned SLOT_OVT  = 1;
  localparam int unsigned SLOT_TEST = 2;
  localparam int unsigned NUM_SLOTS = 3;

  function automatic int unsigned period_max(input int unsigned w, input int unsigned shift);
    return (32'd1 << (w - shift)) - 32'd1;
  endfunction
endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [prc_pkg::SYNC_STAGES];

  for (genvar s = 0; s < int'(prc_pkg::SYNC_STAGES); s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[prc_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/prc_rst_filter.sv
module prc_rst_filter #(
  parameter int unsigned MIN_TICKS = 620
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_lo_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_TICKS + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_TICKS);

  logic [CW-1:0] cnt_q;

  // restart from zero whenever the pin returns high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!pin_lo_i)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CMAX);

  a_r6_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(pin_lo_i));
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_lo_i |=> !qual_o);
endmodule

// File: rtl/prc_chan_gate.sv
module prc_chan_gate #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ovt_i,
  input  logic            load_i,
  input  logic [N_CH-1:0] load_data_i,
  input  logic            capture_i,
  output logic [N_CH-1:0] drv_on_o,
  output logic [N_CH-1:0] status_o
);
  logic [N_CH-1:0] cmd_q;
  logic [N_CH-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '1;
    else if (clr_i)  cmd_q <= '1;
    else if (load_i) cmd_q <= load_data_i;
  end

  for (genvar i = 0; i < int'(N_CH); i++) begin : g_ch
    assign drv_on_o[i] = ~ovt_i & ~cmd_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '1;
    else if (clr_i)     status_q <= '1;
    else if (capture_i) status_q <= ~drv_on_o;
  end

  assign status_o = status_q;

  a_r2_latch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovt_i && !load_i && !clr_i) |=> $stable(cmd_q));
  a_r4_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> cmd_q == $past(load_data_i));
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cmd_q == '1) && (status_q == '1));
  a_r5_hot_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovt_i && capture_i) |=> status_q == '1);
endmodule

// File: rtl/prc_timebase.sv
module prc_timebase #(
  parameter int unsigned W     = 10,
  parameter int unsigned SHIFT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic test_i,
  output logic tick_o,
  output logic osc_half_o
);
  localparam logic [W-1:0] FULL_MAX  = W'(prc_pkg::period_max(W, 0));
  localparam logic [W-1:0] SHORT_MAX = W'(prc_pkg::period_max(W, SHIFT));

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;
  logic         wrap;
  logic         half_q;

  assign lim  = test_i ? SHORT_MAX : FULL_MAX;
  // >= so a switch to the short chain never overruns
  assign wrap = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign tick_o     = wrap;
  assign osc_half_o = test_i & half_q;

  a_r9_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r10_half_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && $past(test_i)) |-> osc_half_o != $past(osc_half_o));
  a_r10_half_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |-> !osc_half_o);
endmodule

// File: rtl/prot_reset_ctrl.sv
module prot_reset_ctrl #(
  parameter int unsigned N_CH          = 8,
  parameter int unsigned RST_MIN_TICKS = 620,
  parameter int unsigned PRESCALE_W    = 10,
  parameter int unsigned TEST_SHIFT    = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_rst_ni,
  input  logic            ovt_i,
  input  logic            test_i,
  input  logic            load_i,
  input  logic [N_CH-1:0] load_data_i,
  input  logic            capture_i,
  output logic [N_CH-1:0] drv_on_o,
  output logic [N_CH-1:0] status_o,
  output logic            sys_rst_no,
  output logic            tick_o,
  output logic            osc_half_o
);
  import prc_pkg::*;

  localparam logic [NUM_SLOTS-1:0] SYNC_RST = NUM_SLOTS'(1) << SLOT_PIN;

  logic [NUM_SLOTS-1:0] raw, syn;
  logic                 qual_rst;

  assign raw[SLOT_PIN]  = ext_rst_ni;
  assign raw[SLOT_OVT]  = ovt_i;
  assign raw[SLOT_TEST] = test_i;

  prc_sync #(.W(NUM_SLOTS), .RST_VAL(SYNC_RST)) i_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  prc_rst_filter #(.MIN_TICKS(RST_MIN_TICKS)) i_filter (
    .clk_i, .rst_ni, .pin_lo_i(~syn[SLOT_PIN]), .qual_o(qual_rst)
  );

  prc_chan_gate #(.N_CH(N_CH)) i_gate (
    .clk_i, .rst_ni,
    .clr_i(qual_rst),
    .ovt_i(syn[SLOT_OVT]),
    .load_i, .load_data_i, .capture_i,
    .drv_on_o, .status_o
  );

  prc_timebase #(.W(PRESCALE_W), .SHIFT(TEST_SHIFT)) i_tb (
    .clk_i, .rst_ni,
    .clr_i(qual_rst),
    .test_i(syn[SLOT_TEST]),
    .tick_o, .osc_half_o
  );

  assign sys_rst_no = rst_ni & ~qual_rst;

  a_r2_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn[SLOT_OVT] |-> drv_on_o == '0);
  a_r7_off_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && $past(!sys_rst_no)) |-> drv_on_o == '0);
endmodule

// File: tb/test_prot_reset_ctrl.sv
module test_prot_reset_ctrl;
  localparam int unsigned N     = 8;
  localparam int unsigned MINT  = 620;
  localparam int unsigned PW    = 10;
  localparam int unsigned SH    = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, ext_rst_ni = 1'b1, ovt_i = 1'b0, test_i = 1'b0;
  logic load_i = 1'b0, capture_i = 1'b0;
  logic [N-1:0] load_data_i = '1;
  logic [N-1:0] drv_on_o, status_o;
  logic sys_rst_no, tick_o, osc_half_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prot_reset_ctrl #(.N_CH(N), .RST_MIN_TICKS(MINT), .PRESCALE_W(PW), .TEST_SHIFT(SH))
  i_prot_reset_ctrl (
    .clk_i(clk), .rst_ni, .ext_rst_ni, .ovt_i, .test_i, .load_i, .load_data_i,
    .capture_i, .drv_on_o, .status_o, .sys_rst_no, .tick_o, .osc_half_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_load(input logic [N-1:0] w);
    load_i = 1'b1; load_data_i = w;
    cyc(1);
    load_i = 1'b0;
  endtask

  task automatic do_capture();
    capture_i = 1'b1;
    cyc(1);
    capture_i = 1'b0;
  endtask

  task automatic t_por();
    cyc(2);
    chk("R8 sys_rst in por", sys_rst_no, 0);
    chk("R8 drv in por", drv_on_o, 0);
    chk("R8 status in por", status_o, 8'hFF);
    rst_ni = 1'b1;
    cyc(1);
    chk("R8 sys_rst after por", sys_rst_no, 1);
  endtask

  task automatic t_load();
    do_load(8'hA5);
    chk("R1 load A5", drv_on_o, 8'h5A);
    do_load(8'h00);
    chk("R1 load 00", drv_on_o, 8'hFF);
    do_load(8'h96);
    chk("R1 load 96", drv_on_o, 8'h69);
    do_capture();
    chk("R5 capture normal", status_o, 8'h96);
  endtask

  task automatic t_ovt_restore();
    do_load(8'hA5);
    ovt_i = 1'b1;
    cyc(1);
    chk("R2 one edge after ovt", drv_on_o, 8'h5A);
    cyc(1);
    chk("R2 outputs off", drv_on_o, 0);
    do_capture();
    chk("R5 capture hot", status_o, 8'hFF);
    cyc(8);
    chk("R2 still off", drv_on_o, 0);
    ovt_i = 1'b0;
    cyc(1);
    chk("R3 one edge after clear", drv_on_o, 0);
    cyc(1);
    chk("R3 restored", drv_on_o, 8'h5A);
  endtask

  task automatic t_ovt_load();
    do_load(8'h3C);
    ovt_i = 1'b1;
    cyc(3);
    do_load(8'h0F);
    chk("R4 hot load stays off", drv_on_o, 0);
    cyc(4);
    ovt_i = 1'b0;
    cyc(2);
    chk("R4 new word applied", drv_on_o, 8'hF0);
  endtask

  task automatic t_short_pulse();
    bit saw = 0;
    do_load(8'h55);
    ext_rst_ni = 1'b0;
    for (int k = 0; k < int'(MINT) - 10; k++) begin
      @(negedge clk);
      if (!sys_rst_no) saw = 1;
    end
    ext_rst_ni = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!sys_rst_no) saw = 1;
    end
    chk("R6 no reset on short pulse", saw, 0);
    chk("R6 drivers kept", drv_on_o, 8'hAA);
  endtask

  task automatic t_long_pulse();
    do_load(8'h00);
    ext_rst_ni = 1'b0;
    cyc(MINT + 1);
    chk("R7 not yet reset", sys_rst_no, 1);
    cyc(1);
    chk("R7 reset asserted", sys_rst_no, 0);
    cyc(2);
    chk("R7 drivers off", drv_on_o, 0);
    cyc(20);
    chk("R7 reset held", sys_rst_no, 0);
    ext_rst_ni = 1'b1;
    cyc(5);
    chk("R7 reset released", sys_rst_no, 1);
    chk("R7 latch cleared", drv_on_o, 0);
    do_capture();
    chk("R7 status cleared", status_o, 8'hFF);
  endtask

  task automatic measure(output int per);
    int g = 0;
    while (!tick_o && g < 4000) begin @(negedge clk); g++; end
    per = 0;
    do begin @(negedge clk); per++; end while (!tick_o && per < 4000);
  endtask

  task automatic t_timebase();
    int p;
    int tog;
    chk("R10 half idle", osc_half_o, 0);
    measure(p);
    chk("R9 normal period", p, 1 << PW);
    test_i = 1'b1;
    cyc(4);
    measure(p);
    chk("R10 test period", p, 1 << (PW - SH));
    tog = 0;
    for (int k = 0; k < 6; k++) begin
      logic prev = osc_half_o;
      @(negedge clk);
      if (osc_half_o != prev) tog++;
    end
    chk("R10 half toggles", tog, 6);
    test_i = 1'b0;
    cyc(4);
    tog = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (osc_half_o) tog++;
    end
    chk("R10 half held low", tog, 0);
    measure(p);
    chk("R9 normal again", p, 1 << PW);
  endtask

  initial begin
    t_por();
    t_load();
    t_ovt_restore();
    t_ovt_load();
    t_short_pulse();
    t_long_pulse();
    t_timebase();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule